// File: doc/BRIEF.md
# Power-Up and Periodic Refresh Sequencer

This block works next to the command scheduler of a multi-bank DRAM controller. After a start pulse it waits a programmable number of cycles for supplies and clocks to settle. It then issues back-to-back mode-register commands that carry a programmed configuration word. Next comes a fixed block of no-operation slots, and one refresh for each of the eight banks is placed in that block. When the block ends, the sequencer raises a flag that releases user traffic.

In normal operation a programmable interval counter posts a group of eight per-bank refreshes at each expiry. The sequencer asks the scheduler for the command slot. Each granted cycle produces one refresh, with the banks taken in ascending order. User traffic stays blocked while a group is pending and for a programmable row-cycle time after the last refresh of the group. The scheduler only needs to watch the request and the traffic-enable outputs and to drive a grant.

Top module: `rfsh_seq`

## Requirements
- R1: During and directly after synchronous reset, cmd_o is NOP (encoding 0), and req_o, init_done_o and user_ok_o are 0.
- R2: The first mode-register command (encoding 1) appears on cmd_o after the (wait_i+2)-th rising edge that follows the edge sampling start_i.
- R3: Exactly MRS_N mode-register commands come out on consecutive cycles. Each carries mode_i in addr_o[MODE_W-1:0], and addr_o bits MODE_W and above are zero.
- R4: In the cycle after the last mode-register command, eight refresh commands (encoding 2) follow on consecutive cycles for banks 0,1,...,7 on bank_o. During this time req_o stays 0.
- R5: The rest of the no-operation block shows NOP. init_done_o rises exactly NOP_BLK cycles after the first initialization refresh appears, and it stays high afterwards.
- R6: req_o rises refi_i cycles after init_done_o rises, and again every refi_i cycles from then on.
- R7: After initialization, a refresh appears on cmd_o only in the cycle after a cycle with req_o and gnt_i both high. The banks come in ascending order, and a cycle without a grant gives NOP.
- R8: req_o falls in the cycle in which the eighth refresh of a group appears. While req_o is low, gnt_i produces no command.
- R9: user_ok_o is 0 before init_done_o and while req_o is high. It rises exactly trc_i cycles after the last refresh of a group appears.
- R10: After initialization, a start_i pulse produces no mode-register command and init_done_o stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins the power-up sequence |
| mode_i | input | MODE_W | Configuration word for mode-register commands |
| wait_i | input | WAIT_W | Settling wait in cycles |
| refi_i | input | CNT_W | Refresh group interval in cycles (at least 1) |
| trc_i | input | CNT_W | Row-cycle hold after a refresh, in cycles |
| gnt_i | input | 1 | Scheduler grant for a pending refresh |
| cmd_o | output | 2 | Command: 0 NOP, 1 mode-register set, 2 refresh |
| bank_o | output | BANK_W | Bank of a refresh command |
| addr_o | output | ADDR_W | Address bus value for a mode-register command |
| req_o | output | 1 | Refresh group pending |
| init_done_o | output | 1 | Initialization complete |
| user_ok_o | output | 1 | User traffic may be scheduled |

## Verification
The power-up sequence is checked cycle by cycle: the settling delay, the mode-register commands with their address, the eight initialization refreshes, and the exact time the ready flag rises. Periodic groups are granted in two patterns. A continuous grant shows that the refreshes can run back to back. A grant with regular gaps shows that a command appears only after a granted cycle and that the bank order survives stalls. Two successive request times confirm that the interval is free-running. Grants given while nothing is pending, and a late start pulse, show that neither input has any effect once the sequencer is idle or running.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int NUM_BANKS = 8;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_MRS  = 2'd1,
        CMD_AREF = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAB,
        ST_MRS,
        ST_BLK,
        ST_RUN
    } init_st_e;

    typedef struct packed {
        cmd_e              op;
        logic [BANK_W-1:0] bank;
    } cmd_t;

    function automatic logic is_last_bank(input logic [BANK_W-1:0] b);
        return b == BANK_W'(NUM_BANKS - 1);
    endfunction

    function automatic logic [BANK_W-1:0] next_bank(input logic [BANK_W-1:0] b);
        return is_last_bank(b) ? '0 : b + 1'b1;
    endfunction

endpackage

// File: rtl/rfsh_init_fsm.sv
module rfsh_init_fsm
    import rfsh_pkg::*;
#(
    parameter int WAIT_W  = 16,
    parameter int MRS_N   = 2,
    parameter int NOP_BLK = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WAIT_W-1:0] wait_i,
    output cmd_t              emit_o,
    output logic              done_o
);
    localparam int MRS_W = $clog2(MRS_N + 1);
    localparam int BLK_W = $clog2(NOP_BLK + 1);

    init_st_e          state_q;
    logic [WAIT_W-1:0] stab_q;
    logic [MRS_W-1:0]  mcnt_q;
    logic [BLK_W-1:0]  blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            stab_q  <= '0;
            mcnt_q  <= '0;
            blk_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_STAB;
                    stab_q  <= '0;
                end
                ST_STAB: if (stab_q == wait_i) begin
                    state_q <= ST_MRS;
                    mcnt_q  <= '0;
                end else begin
                    stab_q <= stab_q + 1'b1;
                end
                ST_MRS: if (mcnt_q == MRS_W'(MRS_N - 1)) begin
                    state_q <= ST_BLK;
                    blk_q   <= '0;
                end else begin
                    mcnt_q <= mcnt_q + 1'b1;
                end
                ST_BLK: if (blk_q == BLK_W'(NOP_BLK)) begin
                    state_q <= ST_RUN;
                end else begin
                    blk_q <= blk_q + 1'b1;
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Command for this slot; refreshes sit at the head of the NOP block.
    always_comb begin
        emit_o = '{op: CMD_NOP, bank: '0};
        if (state_q == ST_MRS) begin
            emit_o.op = CMD_MRS;
        end else if (state_q == ST_BLK && blk_q < BLK_W'(NUM_BANKS)) begin
            emit_o.op   = CMD_AREF;
            emit_o.bank = blk_q[BANK_W-1:0];
        end
    end

    assign done_o = (state_q == ST_RUN);

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (emit_o.op == CMD_NOP));

endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval
    import rfsh_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [CNT_W-1:0]  refi_i,
    input  logic              gnt_i,
    output logic              req_o,
    output logic              issue_o,
    output logic [BANK_W-1:0] bank_o
);
    logic [CNT_W-1:0]  cnt_q;
    logic              pend_q;
    logic [BANK_W-1:0] bank_q;
    logic              trig;

    assign trig    = run_i && (cnt_q == refi_i - CNT_W'(1));
    assign issue_o = pend_q && gnt_i;
    assign req_o   = pend_q;
    assign bank_o  = bank_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            bank_q <= '0;
        end else begin
            cnt_q <= trig ? '0 : cnt_q + 1'b1;
            if (issue_o) begin
                bank_q <= next_bank(bank_q);
            end
            if (trig) begin
                pend_q <= 1'b1;
            end else if (issue_o && is_last_bank(bank_q)) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_o |=> $stable(bank_q));

    // R8
    group_end_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_o && is_last_bank(bank_q) && !trig) |=> !req_o);

endmodule

// File: rtl/rfsh_trc_guard.sv
module rfsh_trc_guard #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] trc_i,
    output logic             clear_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= trc_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign clear_o = (cnt_q == '0);

    // R9
    trc_block_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && trc_i != '0) |=> !clear_o);

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int MODE_W  = 10,
    parameter int CNT_W   = 16,
    parameter int WAIT_W  = 16,
    parameter int MRS_N   = 2,
    parameter int NOP_BLK = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic [CNT_W-1:0]  refi_i,
    input  logic [CNT_W-1:0]  trc_i,
    input  logic              gnt_i,
    output logic [1:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              req_o,
    output logic              init_done_o,
    output logic              user_ok_o
);
    localparam int PAD_W = ADDR_W - MODE_W;

    cmd_t              init_emit;
    cmd_t              next_cmd;
    cmd_t              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done;
    logic              run_req;
    logic              run_issue;
    logic [BANK_W-1:0] run_bank;
    logic              trc_clear;

    rfsh_init_fsm #(
        .WAIT_W (WAIT_W),
        .MRS_N  (MRS_N),
        .NOP_BLK(NOP_BLK)
    ) u_init (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .wait_i (wait_i),
        .emit_o (init_emit),
        .done_o (done)
    );

    rfsh_interval #(
        .CNT_W(CNT_W)
    ) u_intv (
        .clk    (clk),
        .rst    (rst),
        .run_i  (done),
        .refi_i (refi_i),
        .gnt_i  (gnt_i),
        .req_o  (run_req),
        .issue_o(run_issue),
        .bank_o (run_bank)
    );

    rfsh_trc_guard #(
        .CNT_W(CNT_W)
    ) u_trc (
        .clk    (clk),
        .rst    (rst),
        .load_i (run_issue),
        .trc_i  (trc_i),
        .clear_o(trc_clear)
    );

    always_comb begin
        if (!done) begin
            next_cmd = init_emit;
        end else if (run_issue) begin
            next_cmd = '{op: CMD_AREF, bank: run_bank};
        end else begin
            next_cmd = '{op: CMD_NOP, bank: '0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '{op: CMD_NOP, bank: '0};
            addr_q <= '0;
        end else begin
            cmd_q  <= next_cmd;
            addr_q <= (next_cmd.op == CMD_MRS) ? {{PAD_W{1'b0}}, mode_i} : '0;
        end
    end

    assign cmd_o       = cmd_q.op;
    assign bank_o      = cmd_q.bank;
    assign addr_o      = addr_q;
    assign req_o       = run_req;
    assign init_done_o = done;
    assign user_ok_o   = done && !run_req && trc_clear;

    // R10
    mrs_only_init_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_MRS) |-> !init_done_o);

    // R3
    mode_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_MRS) |-> (addr_o[ADDR_W-1:MODE_W] == '0));

    // R7
    aref_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (init_done_o && $past(init_done_o) && cmd_o == CMD_AREF) |-> $past(req_o && gnt_i));

    // R4
    bank_order_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_AREF && $past(cmd_o) == CMD_AREF) |-> (bank_o == BANK_W'($past(bank_o) + 1'b1)));

    // R9
    trc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_AREF && trc_i != '0) |-> !user_ok_o);

endmodule

// File: tb/tb_rfsh_seq.sv
module tb_rfsh_seq;
    import rfsh_pkg::*;

    localparam int ADDR_W  = 20;
    localparam int MODE_W  = 10;
    localparam int CNT_W   = 16;
    localparam int WAIT_W  = 16;
    localparam int MRS_N   = 2;
    localparam int NOP_BLK = 1024;
    localparam int T_WAIT  = 6;
    localparam int T_REFI  = 40;
    localparam int T_TRC   = 5;
    localparam logic [MODE_W-1:0] MODE_VAL = 10'h2A5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              gnt_i = 1'b0;
    logic [MODE_W-1:0] mode_i = MODE_VAL;
    logic [WAIT_W-1:0] wait_i = WAIT_W'(T_WAIT);
    logic [CNT_W-1:0]  refi_i = CNT_W'(T_REFI);
    logic [CNT_W-1:0]  trc_i = CNT_W'(T_TRC);
    logic [1:0]        cmd_o;
    logic [BANK_W-1:0] bank_o;
    logic [ADDR_W-1:0] addr_o;
    logic              req_o, init_done_o, user_ok_o;

    rfsh_seq #(
        .ADDR_W(ADDR_W), .MODE_W(MODE_W), .CNT_W(CNT_W),
        .WAIT_W(WAIT_W), .MRS_N(MRS_N), .NOP_BLK(NOP_BLK)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .wait_i(wait_i), .refi_i(refi_i), .trc_i(trc_i), .gnt_i(gnt_i),
        .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o), .req_o(req_o),
        .init_done_o(init_done_o), .user_ok_o(user_ok_o)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int d_cyc = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "cmd in reset", int'(cmd_o), 0);
        check("R1", "init_done in reset", int'(init_done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "req after reset", int'(req_o), 0);
        check("R1", "user_ok after reset", int'(user_ok_o), 0);
        check("R1", "cmd after reset", int'(cmd_o), 0);
    endtask

    task automatic t_init();
        int c0;
        int first_a;
        int bad;
        int guard;
        @(negedge clk);
        start_i = 1'b1;
        c0 = cyc;
        @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (cmd_o == 2'd0 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        // sampling edge c0+1, MRS registered on edge c0+1+T_WAIT+2
        check("R2", "first MRS cycle", cyc - c0, T_WAIT + 3);
        for (int i = 0; i < MRS_N; i++) begin
            check("R3", "MRS op", int'(cmd_o), 1);
            check("R3", "MRS addr", int'(addr_o), int'(MODE_VAL));
            @(negedge clk);
        end
        first_a = cyc;
        for (int b = 0; b < NUM_BANKS; b++) begin
            check("R4", "init refresh op", int'(cmd_o), 2);
            check("R4", "init refresh bank", int'(bank_o), b);
            if (b == 0) check("R4", "req during init", int'(req_o), 0);
            @(negedge clk);
        end
        bad = 0;
        guard = 0;
        while (!init_done_o && guard < 2 * NOP_BLK) begin
            if (cmd_o != 2'd0 || user_ok_o) bad++;
            @(negedge clk);
            guard++;
        end
        check("R5", "non-NOP slots in block", bad, 0);
        check("R5", "init_done delay", cyc - first_a, NOP_BLK);
        d_cyc = cyc;
    endtask

    task automatic t_wait_req(input int exp_off);
        int guard = 0;
        while (!req_o && guard < 4 * T_REFI) begin
            @(negedge clk);
            guard++;
        end
        check("R6", "request time", cyc - d_cyc, exp_off);
        check("R9", "user_ok while pending", int'(user_ok_o), 0);
        check("R5", "init_done held", int'(init_done_o), 1);
    endtask

    task automatic t_group(input bit gaps);
        int got = 0;
        int k = 0;
        int last_a;
        int guard;
        bit exp_issue;
        while (got < NUM_BANKS && k < 100) begin
            gnt_i = gaps ? (k % 3 != 1) : 1'b1;
            exp_issue = gnt_i && req_o;
            @(negedge clk);
            k++;
            if (exp_issue) begin
                check("R7", "granted refresh op", int'(cmd_o), 2);
                check("R7", "granted refresh bank", int'(bank_o), got);
                got++;
            end else begin
                check("R7", "no refresh without grant", int'(cmd_o), 0);
            end
        end
        gnt_i = 1'b0;
        check("R8", "req after eighth refresh", int'(req_o), 0);
        last_a = cyc;
        guard = 0;
        while (!user_ok_o && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        check("R9", "user_ok delay after group", cyc - last_a, T_TRC);
        for (int i = 0; i < 3; i++) begin
            gnt_i = 1'b1;
            @(negedge clk);
            check("R8", "grant while idle", int'(cmd_o), 0);
        end
        gnt_i = 1'b0;
    endtask

    task automatic t_late_start();
        int bad = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (cmd_o == 2'd1) bad++;
            if (!init_done_o) bad++;
            @(negedge clk);
        end
        check("R10", "MRS or lost init after late start", bad, 0);
    endtask

    initial begin
        t_reset();
        t_init();
        t_wait_req(T_REFI);
        t_group(1'b0);
        t_wait_req(2 * T_REFI);
        t_group(1'b1);
        t_late_start();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 200000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule